// File: doc/BRIEF.md
# PWM-Referenced Successive Approximation Measurement Controller

This block measures slow analog signals without a parallel DAC. At a start request it drives a channel number onto an external analog multiplexer and holds it there for the whole conversion. It then runs a binary search whose trial reference is the duty cycle of a PWM output. Off chip, that output is low-pass filtered into a DC level and compared against the selected signal. The single comparator bit comes back into the block, and after the search ends the final duty-cycle code is reported as the measurement.

A PWM-derived level is only correct once the external filter has settled. For that reason every change of the trial code is followed by a wait of a programmable number of whole PWM periods, and only then is the comparator sampled. One extra wait of the same length comes before the first trial so the multiplexer output can stabilise. Turning codes into volts is left to the user of the result.

Top module: `sarpwm_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, done, result, muxSel and pwmOut are all 0.
- R2: A start request accepted while idle copies chanSel into muxSel. muxSel stays unchanged until the next accepted start, and that includes the whole conversion.
- R3: The PWM period is 2^DUTY_W clock cycles, and pwmOut is high for as many cycles per period as the current duty code. With a code of 0 it never goes high. The period restarts whenever the code changes during a search.
- R4: The search tries bits from the most significant down to the least. Each trial sets the bit under test. comparator input 1 means the reference is above the input and clears the bit; 0 keeps it. For an input level L in duty counts, the result is the largest code not above L, which saturates at 2^DUTY_W-1.
- R5: Each trial, and the multiplexer wait before the first one, lasts (settleSel+1) full PWM periods plus a short synchronizer drain. A conversion therefore keeps busy high for at least (DUTY_W+1)*(settleSel+1)*2^DUTY_W cycles and at most 8*(DUTY_W+1) cycles more.
- R6: done is high for exactly one clock, with busy low, and in that cycle result already holds the new value. result changes in no other cycle.
- R7: A start request made while busy is ignored. muxSel keeps the original channel, the result is that of the original channel, and no second conversion follows.
- R8: A start request made in the cycle in which done is high is accepted. busy is high in the next cycle, and the new conversion measures the newly requested channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request to begin a conversion; accepted only when idle |
| chanSel | input | SEL_W | Channel to measure, latched at an accepted start |
| settleSel | input | SETTLE_W | Settle wait per step, in PWM periods minus one, latched at start |
| cmpIn | input | 1 | Asynchronous comparator output, 1 when reference exceeds input |
| muxSel | output | SEL_W | Select lines for the external analog multiplexer |
| pwmOut | output | 1 | PWM output whose filtered level is the trial reference |
| busy | output | 1 | High while a conversion is running |
| done | output | 1 | One-cycle pulse marking a fresh result |
| result | output | DUTY_W | Last completed measurement, as a duty code |

## Verification
The end of one conversion and the acceptance of the next can happen in the same cycle, because a start request may be present on the very clock in which done pulses. The bench waits for done, raises startReq with a new channel in that same cycle, and checks three things: done carried the first channel's correct code, busy rose on the following clock, and the second conversion matched the new channel's level. A start request made in the final busy cycle is the opposite case and must not start a conversion; that case is covered by the start-while-busy test and an assertion.

// File: rtl/sarpwm_pkg.sv
package sarpwm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_DRAIN  = 2'd2
  } sarState_t;

  // one-cycle strobes from control to datapath
  typedef struct packed {
    logic latchSel;
    logic clearDuty;
    logic restartPwm;
    logic setBit;
    logic clearBit;
    logic capture;
  } ctrlStrobe_t;

endpackage

// File: rtl/sarpwm_datapath.sv
module sarpwm_datapath
  import sarpwm_pkg::*;
#(
  parameter int DUTY_W      = 8,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (DUTY_W > 1) ? $clog2(DUTY_W) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [IDX_W-1:0]  setIdx,
  input  logic [IDX_W-1:0]  clrIdx,
  input  logic [SEL_W-1:0]  chanSel,
  input  logic              cmpIn,
  output logic [SEL_W-1:0]  muxSel,
  output logic              pwmOut,
  output logic [DUTY_W-1:0] result,
  output logic [DUTY_W-1:0] dutyQ,
  output logic              cmpSync
);

  logic [DUTY_W-1:0]      dutyNext;
  logic [DUTY_W-1:0]      pwmCnt;
  logic [SEL_W-1:0]       selQ;
  logic [DUTY_W-1:0]      resultQ;
  logic [SYNC_STAGES-1:0] syncQ;

  // trial code update: clear of the decided bit and set of the next bit may coincide
  always_comb begin
    dutyNext = dutyQ;
    if (strobe.clearDuty) dutyNext = '0;
    if (strobe.clearBit)  dutyNext[clrIdx] = 1'b0;
    if (strobe.setBit)    dutyNext[setIdx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyQ   <= '0;
      pwmCnt  <= '0;
      selQ    <= '0;
      resultQ <= '0;
    end else begin
      dutyQ <= dutyNext;
      if (strobe.restartPwm) pwmCnt <= '0;
      else                   pwmCnt <= pwmCnt + 1'b1;
      if (strobe.latchSel) selQ <= chanSel;
      if (strobe.capture)  resultQ <= dutyNext;
    end
  end

  // comparator synchronizer chain
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= cmpIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], cmpIn};
      end
    end
  endgenerate

  assign cmpSync = syncQ[SYNC_STAGES-1];
  assign pwmOut  = (pwmCnt < dutyQ);
  assign muxSel  = selQ;
  assign result  = resultQ;

endmodule

// File: rtl/sarpwm_ctrl.sv
module sarpwm_ctrl
  import sarpwm_pkg::*;
#(
  parameter int DUTY_W      = 8,
  parameter int SETTLE_W    = 3,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (DUTY_W > 1) ? $clog2(DUTY_W) : 1,
  localparam int TIMER_W    = SETTLE_W + DUTY_W + 1,
  localparam int DRAIN_LEN  = SYNC_STAGES + 1,
  localparam int DRAIN_W    = $clog2(DRAIN_LEN + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic [SETTLE_W-1:0] settleSel,
  input  logic                cmpSync,
  output ctrlStrobe_t         strobe,
  output logic [IDX_W-1:0]    setIdx,
  output logic [IDX_W-1:0]    clrIdx,
  output logic                busy,
  output logic                done
);

  localparam logic [IDX_W-1:0] MSB_IDX = IDX_W'(DUTY_W - 1);

  sarState_t           stateQ;
  logic [TIMER_W-1:0]  timerQ;
  logic [TIMER_W-1:0]  settleLim;
  logic [SETTLE_W-1:0] settleQ;
  logic [DRAIN_W-1:0]  drainQ;
  logic [IDX_W-1:0]    bitIdx;
  logic                trialOn;
  logic                doneQ;
  logic                drainEnd;
  logic                lastBit;

  assign settleLim = ((TIMER_W'(settleQ) + 1'b1) << DUTY_W) - 1'b1;
  assign drainEnd  = (stateQ == ST_DRAIN) && (drainQ == DRAIN_W'(DRAIN_LEN - 1));
  assign lastBit   = (bitIdx == '0);

  always_comb begin
    strobe = '0;
    clrIdx = bitIdx;
    setIdx = bitIdx;
    if (stateQ == ST_IDLE && startReq) begin
      strobe.latchSel   = 1'b1;
      strobe.clearDuty  = 1'b1;
      strobe.restartPwm = 1'b1;
    end else if (drainEnd) begin
      if (!trialOn) begin
        strobe.setBit     = 1'b1;
        strobe.restartPwm = 1'b1;
      end else begin
        strobe.clearBit = cmpSync;
        if (lastBit) begin
          strobe.capture = 1'b1;
        end else begin
          setIdx            = bitIdx - 1'b1;
          strobe.setBit     = 1'b1;
          strobe.restartPwm = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      timerQ  <= '0;
      settleQ <= '0;
      drainQ  <= '0;
      bitIdx  <= '0;
      trialOn <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (stateQ)
        ST_IDLE: begin
          if (startReq) begin
            settleQ <= settleSel;
            timerQ  <= '0;
            bitIdx  <= MSB_IDX;
            trialOn <= 1'b0;
            stateQ  <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (timerQ == settleLim) begin
            timerQ <= '0;
            drainQ <= '0;
            stateQ <= ST_DRAIN;
          end else begin
            timerQ <= timerQ + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (drainEnd) begin
            if (!trialOn) begin
              trialOn <= 1'b1;
              stateQ  <= ST_SETTLE;
            end else if (lastBit) begin
              doneQ  <= 1'b1;
              stateQ <= ST_IDLE;
            end else begin
              bitIdx <= bitIdx - 1'b1;
              stateQ <= ST_SETTLE;
            end
          end else begin
            drainQ <= drainQ + 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign busy = (stateQ != ST_IDLE);
  assign done = doneQ;

endmodule

// File: rtl/sarpwm_top.sv
module sarpwm_top
  import sarpwm_pkg::*;
#(
  parameter int DUTY_W      = 8,
  parameter int SEL_W       = 3,
  parameter int SETTLE_W    = 3,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (DUTY_W > 1) ? $clog2(DUTY_W) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic [SEL_W-1:0]    chanSel,
  input  logic [SETTLE_W-1:0] settleSel,
  input  logic                cmpIn,
  output logic [SEL_W-1:0]    muxSel,
  output logic                pwmOut,
  output logic                busy,
  output logic                done,
  output logic [DUTY_W-1:0]   result
);

  ctrlStrobe_t       strobe;
  logic [IDX_W-1:0]  setIdx;
  logic [IDX_W-1:0]  clrIdx;
  logic [DUTY_W-1:0] dutyQ;
  logic              cmpSync;

  sarpwm_ctrl #(
    .DUTY_W(DUTY_W), .SETTLE_W(SETTLE_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .settleSel(settleSel),
    .cmpSync(cmpSync), .strobe(strobe), .setIdx(setIdx), .clrIdx(clrIdx),
    .busy(busy), .done(done)
  );

  sarpwm_datapath #(
    .DUTY_W(DUTY_W), .SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .setIdx(setIdx), .clrIdx(clrIdx),
    .chanSel(chanSel), .cmpIn(cmpIn), .muxSel(muxSel), .pwmOut(pwmOut),
    .result(result), .dutyQ(dutyQ), .cmpSync(cmpSync)
  );

endmodule

// File: rtl/sarpwm_checker.sv
module sarpwm_checker #(
  parameter int DUTY_W = 8,
  parameter int SEL_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic              busy,
  input logic              done,
  input logic              pwmOut,
  input logic [SEL_W-1:0]  muxSel,
  input logic [DUTY_W-1:0] result,
  input logic [DUTY_W-1:0] dutyQ
);

  // R1: outputs idle right after a reset cycle
  a_r1_reset_idle: assert property (@(posedge clk)
    !rstN |=> (!busy && !done && result == '0));

  // R2: mux select frozen while converting
  a_r2_sel_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(muxSel));

  // R3: zero code gives a silent PWM output
  a_r3_pwm_zero: assert property (@(posedge clk) disable iff (!rstN)
    (dutyQ == '0) |-> !pwmOut);

  // R6: done lasts one cycle and comes with busy low
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r6_result_on_done: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> done);

  // R7: start while busy never interrupts the conversion
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |=> (busy || done));

  // R8: start while idle (including the done cycle) is taken
  a_r8_start_taken: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq) |=> busy);

endmodule

bind sarpwm_top sarpwm_checker #(.DUTY_W(DUTY_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .busy(busy), .done(done),
  .pwmOut(pwmOut), .muxSel(muxSel), .result(result), .dutyQ(u_dp.dutyQ)
);

// File: tb/tb_sarpwm_top.sv
module tb_sarpwm_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam int SW         = 3;
  localparam int STW        = 3;
  localparam int PERIOD     = 1 << DW;
  localparam int WD_LIMIT   = 190000;
  localparam int VEC_N      = 8;

  typedef struct packed {
    logic [SW-1:0]  ch;
    logic [9:0]     lvl;
    logic [STW-1:0] st;
  } vec_t;

  localparam vec_t VECS [VEC_N] = '{
    '{ch: 3'd0, lvl: 10'd0,   st: 3'd0},
    '{ch: 3'd1, lvl: 10'd255, st: 3'd0},
    '{ch: 3'd2, lvl: 10'd300, st: 3'd0},
    '{ch: 3'd3, lvl: 10'd128, st: 3'd1},
    '{ch: 3'd4, lvl: 10'd127, st: 3'd0},
    '{ch: 3'd5, lvl: 10'd1,   st: 3'd0},
    '{ch: 3'd6, lvl: 10'd170, st: 3'd2},
    '{ch: 3'd7, lvl: 10'd85,  st: 3'd0}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic [SW-1:0] chanSel = '0;
  logic [STW-1:0] settleSel = '0;
  logic          cmpIn = 1'b0;
  logic [SW-1:0] muxSel;
  logic          pwmOut;
  logic          busy;
  logic          done;
  logic [DW-1:0] result;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int chanLevel [8];
  logic [PERIOD-1:0] hist = '0;
  int histPtr = 0;
  int winSum = 0;

  sarpwm_top #(.DUTY_W(DW), .SEL_W(SW), .SETTLE_W(STW)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .chanSel(chanSel),
    .settleSel(settleSel), .cmpIn(cmpIn), .muxSel(muxSel), .pwmOut(pwmOut),
    .busy(busy), .done(done), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // external filter and comparator model: moving average over one PWM period
  always @(negedge clk) begin
    winSum = winSum + int'(pwmOut) - int'(hist[histPtr]);
    hist[histPtr] = pwmOut;
    histPtr = (histPtr + 1) % PERIOD;
    cmpIn = (winSum > chanLevel[muxSel]);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_code(input int lvl);
    int code = 0;
    for (int b = DW - 1; b >= 0; b--) begin
      if ((code | (1 << b)) <= lvl) code = code | (1 << b);
    end
    return code;
  endfunction

  task automatic start_conv(input logic [SW-1:0] ch, input logic [STW-1:0] st);
    @(negedge clk);
    chanSel = ch;
    settleSel = st;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic pwm_count(output int highs);
    highs = 0;
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk);
      if (pwmOut) highs++;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WD_LIMIT);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    int cyc, exp, minC, highs;
    for (int i = 0; i < 8; i++) chanLevel[i] = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(!busy && !done && result == 0 && muxSel == 0 && !pwmOut, "R1 reset",
          int'({busy, done, pwmOut}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && result == 0 && muxSel == 0, "R1 after reset",
          int'(result), 0);

    // vector table
    for (int v = 0; v < VEC_N; v++) begin
      chanLevel[VECS[v].ch] = int'(VECS[v].lvl);
      start_conv(VECS[v].ch, VECS[v].st);
      check(busy && muxSel == VECS[v].ch, "R2 select latched", int'(muxSel), int'(VECS[v].ch));
      wait_done(cyc);
      exp = model_code(int'(VECS[v].lvl));
      check(result == exp, "R4 result", int'(result), exp);
      check(!busy && muxSel == VECS[v].ch, "R6/R2 done state", int'(muxSel), int'(VECS[v].ch));
      minC = (DW + 1) * (int'(VECS[v].st) + 1) * PERIOD;
      check(cyc >= minC && cyc <= minC + 8 * (DW + 1), "R5 duration", cyc, minC);
      @(negedge clk);
      check(!done && result == exp, "R6 done single", int'(done), 0);
      if (v % 2 == 1) begin
        pwm_count(highs);
        check(highs == exp, "R3 pwm duty", highs, exp);
      end
    end

    // R3: zero duty stays low for a whole period
    chanLevel[2] = 0;
    start_conv(3'd2, 3'd0);
    wait_done(cyc);
    pwm_count(highs);
    check(highs == 0, "R3 zero duty", highs, 0);

    // R7: start while busy is ignored
    chanLevel[4] = 200;
    chanLevel[6] = 50;
    start_conv(3'd4, 3'd0);
    repeat (700) @(negedge clk);
    start_conv(3'd6, 3'd1);
    check(busy && muxSel == 3'd4, "R7 select kept", int'(muxSel), 4);
    wait_done(cyc);
    check(result == model_code(200), "R7 original result", int'(result), model_code(200));
    repeat (5) @(negedge clk);
    check(!busy && muxSel == 3'd4, "R7 no second conversion", int'(busy), 0);

    // R8: start in the done cycle
    chanLevel[1] = 99;
    chanLevel[5] = 231;
    start_conv(3'd1, 3'd0);
    wait_done(cyc);
    chanSel = 3'd5;
    settleSel = 3'd0;
    startReq = 1'b1;
    check(result == model_code(99), "R8 first result", int'(result), model_code(99));
    @(negedge clk);
    startReq = 1'b0;
    check(busy && muxSel == 3'd5, "R8 restart", int'(muxSel), 5);
    wait_done(cyc);
    check(result == model_code(231), "R8 second result", int'(result), model_code(231));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule